// File: doc/BRIEF.md
# Hardware Stack and Call/Return Unit

This unit holds a stack pointer and carries out four stack instructions, each completed in one clock: push a register value, pop into a register, call a subroutine and return from it. The stack lives in an external word-addressed memory with a combinational read port and a write port that commits on the rising clock edge. The stack grows toward lower addresses, and the pointer always names the topmost occupied word. Storing uses pre-decrement addressing and loading uses post-increment addressing.

A call stores the address of the following instruction (the current program counter plus one) on the stack and redirects the program counter to the call target in the same clock. A return loads the top word straight into the next program counter. Nested calls need no extra state because every return address sits in memory in last-in, first-out order. When no stack instruction is present, the unit proposes the current program counter plus one as the next program counter.

Top module: `stack_call_unit`

## Requirements
- R1: While reset is asserted and after its release, the stack pointer holds the base value SP_BASE (default 0x0000).
- R2: Push (operation code 1) drives the memory address to SP-1, asserts the write strobe with the push data, and leaves SP-1 in the stack pointer after the clock edge.
- R3: Pop (operation code 2) reads at address SP with no memory write, asserts the register write with the selected destination index and the read word, and leaves SP+1 in the stack pointer.
- R4: Call (operation code 3) writes the current program counter plus one to address SP-1, gives the call target as the next program counter and leaves SP-1 in the stack pointer, all in one clock.
- R5: Return (operation code 4) reads at address SP, gives the read word as the next program counter, writes no register and no memory, and leaves SP+1 in the stack pointer.
- R6: With operation code 0 the next program counter is the current one plus one, neither the memory nor the register write is asserted, and the stack pointer stays unchanged.
- R7: Stack pointer and program counter arithmetic wrap modulo 2^16: a push from 0x0000 stores at 0xFFFF, a pop at 0xFFFF returns the pointer to 0x0000, and program counter 0xFFFF advances to 0x0000.
- R8: Operation codes 5, 6 and 7 behave exactly like operation code 0.
- R9: Nested calls followed by the same number of returns deliver the stored return addresses in reverse order of the calls.
- R10: A pop can target any register index from 0 to 2^RIDX_W-1, and that index appears unchanged on the register write address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_code | input | 3 | Stack instruction: 0 none, 1 push, 2 pop, 3 call, 4 return |
| push_data | input | WORD_W | Register value to store on a push |
| pop_dst | input | RIDX_W | Destination register index for a pop |
| call_target | input | WORD_W | Jump target for a call |
| pc_cur | input | WORD_W | Current program counter |
| mem_rdata | input | WORD_W | Combinational read data from stack memory |
| mem_addr | output | WORD_W | Stack memory address |
| mem_we | output | 1 | Stack memory write strobe |
| mem_wdata | output | WORD_W | Stack memory write data |
| rf_we | output | 1 | Register file write enable for a pop |
| rf_waddr | output | RIDX_W | Register file write index |
| rf_wdata | output | WORD_W | Register file write data |
| pc_next | output | WORD_W | Next program counter |
| sp_out | output | WORD_W | Current stack pointer |

## Verification
A call joins a memory store with a program counter redirect, and a return joins a memory load with a redirect; in both the pointer moves in the same clock. The bench provokes these by issuing three nested calls with distinct program counters and targets, then three returns, plus a call at program counter 0xFFFF, so that the stored link, the jump and the pointer step are all judged against one scoreboard entry per clock. Each return must present the link of the matching call on the next program counter while the pointer climbs back by one, which only holds if the earlier store reached the right address.

// File: rtl/stk_pkg.sv
package stk_pkg;

  typedef enum logic [2:0] {
    STK_NONE = 3'd0,
    STK_PUSH = 3'd1,
    STK_POP  = 3'd2,
    STK_CALL = 3'd3,
    STK_RET  = 3'd4
  } stk_op_e;

  typedef struct packed {
    logic store;    // write a word at the pre-decremented pointer
    logic load;     // read a word at the pointer
    logic link;     // store carries the return address, PC takes target
    logic load_pc;  // read word goes to the next PC
    logic load_rf;  // read word goes to the register file
    logic sp_down;  // pointer steps down
    logic sp_up;    // pointer steps up
  } stk_ctl_t;

endpackage

// File: rtl/stk_rst_sync.sv
module stk_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = 1'b1;
    end else begin : g_multi
      always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/stk_decode.sv
module stk_decode
  import stk_pkg::*;
(
  input  logic     run,
  input  logic [2:0] op_code,
  output stk_ctl_t ctl
);

  stk_op_e op;

  always_comb begin
    op  = stk_op_e'(op_code);
    ctl = '0;
    if (run) begin
      case (op)
        STK_PUSH: begin
          ctl.store   = 1'b1;
          ctl.sp_down = 1'b1;
        end
        STK_POP: begin
          ctl.load    = 1'b1;
          ctl.load_rf = 1'b1;
          ctl.sp_up   = 1'b1;
        end
        STK_CALL: begin
          ctl.store   = 1'b1;
          ctl.link    = 1'b1;
          ctl.sp_down = 1'b1;
        end
        STK_RET: begin
          ctl.load    = 1'b1;
          ctl.load_pc = 1'b1;
          ctl.sp_up   = 1'b1;
        end
        default: ctl = '0;
      endcase
    end
  end

endmodule

// File: rtl/stk_addr_path.sv
module stk_addr_path
  import stk_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic [WORD_W-1:0] sp_q,
  input  stk_ctl_t          ctl,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] sp_d,
  output logic              sp_en
);

  localparam logic [WORD_W-1:0] ONE = {{(WORD_W-1){1'b0}}, 1'b1};

  logic [WORD_W-1:0] sp_dec;
  logic [WORD_W-1:0] sp_inc;

  always_comb begin
    sp_dec   = sp_q - ONE;
    sp_inc   = sp_q + ONE;
    // stores use the pre-decremented pointer, loads the pointer itself
    mem_addr = ctl.store ? sp_dec : sp_q;
    sp_en    = ctl.sp_down | ctl.sp_up;
    sp_d     = ctl.sp_down ? sp_dec : sp_inc;
  end

endmodule

// File: rtl/stk_pc_path.sv
module stk_pc_path
  import stk_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic [WORD_W-1:0] pc_cur,
  input  logic [WORD_W-1:0] call_target,
  input  logic [WORD_W-1:0] push_data,
  input  logic [WORD_W-1:0] mem_rdata,
  input  stk_ctl_t          ctl,
  output logic [WORD_W-1:0] pc_next,
  output logic [WORD_W-1:0] mem_wdata
);

  localparam logic [WORD_W-1:0] ONE = {{(WORD_W-1){1'b0}}, 1'b1};

  logic [WORD_W-1:0] pc_link;

  always_comb begin
    pc_link = pc_cur + ONE;
    if (ctl.link)         pc_next = call_target;
    else if (ctl.load_pc) pc_next = mem_rdata;
    else                  pc_next = pc_link;
    mem_wdata = ctl.link ? pc_link : push_data;
  end

endmodule

// File: rtl/stack_call_unit.sv
module stack_call_unit
  import stk_pkg::*;
#(
  parameter int               WORD_W  = 16,
  parameter int               RIDX_W  = 3,
  parameter int               SYNC_ST = 2,
  parameter logic [WORD_W-1:0] SP_BASE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        op_code,
  input  logic [WORD_W-1:0] push_data,
  input  logic [RIDX_W-1:0] pop_dst,
  input  logic [WORD_W-1:0] call_target,
  input  logic [WORD_W-1:0] pc_cur,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [WORD_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              rf_we,
  output logic [RIDX_W-1:0] rf_waddr,
  output logic [WORD_W-1:0] rf_wdata,
  output logic [WORD_W-1:0] pc_next,
  output logic [WORD_W-1:0] sp_out
);

  localparam logic [WORD_W-1:0] ONE = {{(WORD_W-1){1'b0}}, 1'b1};

  logic              rst_ok_n;
  stk_ctl_t          ctl;
  logic [WORD_W-1:0] sp_q;
  logic [WORD_W-1:0] sp_d;
  logic              sp_en;

  stk_rst_sync #(.STAGES(SYNC_ST)) u_rst (
    .clk        (clk),
    .arst_n     (rst_n),
    .rst_sync_n (rst_ok_n)
  );

  stk_decode u_dec (
    .run     (rst_ok_n),
    .op_code (op_code),
    .ctl     (ctl)
  );

  stk_addr_path #(.WORD_W(WORD_W)) u_addr (
    .sp_q     (sp_q),
    .ctl      (ctl),
    .mem_addr (mem_addr),
    .sp_d     (sp_d),
    .sp_en    (sp_en)
  );

  stk_pc_path #(.WORD_W(WORD_W)) u_pc (
    .pc_cur      (pc_cur),
    .call_target (call_target),
    .push_data   (push_data),
    .mem_rdata   (mem_rdata),
    .ctl         (ctl),
    .pc_next     (pc_next),
    .mem_wdata   (mem_wdata)
  );

  always_ff @(posedge clk or negedge rst_ok_n) begin
    if (!rst_ok_n)  sp_q <= SP_BASE;
    else if (sp_en) sp_q <= sp_d;
  end

  assign mem_we   = ctl.store;
  assign rf_we    = ctl.load_rf;
  assign rf_waddr = pop_dst;
  assign rf_wdata = mem_rdata;
  assign sp_out   = sp_q;

  AST_PUSH_PREDEC: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (op_code == STK_PUSH) |=> (sp_q == $past(sp_q) - ONE)); // R2

  AST_STORE_BELOW_TOP: assert property (@(posedge clk) disable iff (!rst_ok_n)
    mem_we |-> (mem_addr == sp_q - ONE)); // R2

  AST_POP_POSTINC: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (op_code == STK_POP) |=> (sp_q == $past(sp_q) + ONE)); // R3

  AST_POP_NO_STORE: assert property (@(posedge clk) disable iff (!rst_ok_n)
    rf_we |-> (!mem_we && mem_addr == sp_q)); // R3

  AST_CALL_LINK_JUMP: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (op_code == STK_CALL) |-> (mem_we && pc_next == call_target && mem_wdata == pc_cur + ONE)); // R4

  AST_RET_TO_PC: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (op_code == STK_RET) |-> (pc_next == mem_rdata && !rf_we && !mem_we)); // R5

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (op_code == STK_NONE || op_code > STK_RET) |=> $stable(sp_q)); // R6

  AST_ONE_WRITE_PORT: assert property (@(posedge clk) disable iff (!rst_ok_n)
    $countones({mem_we, rf_we}) <= 1); // R3

endmodule

// File: tb/stack_call_unit_tb.sv
module stack_call_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  op_code;
  logic [15:0] push_data, call_target, pc_cur, mem_rdata;
  logic [2:0]  pop_dst;
  logic [15:0] mem_addr, mem_wdata, rf_wdata, pc_next, sp_out;
  logic        mem_we, rf_we;
  logic [2:0]  rf_waddr;

  always #4 clk = ~clk;  // 125 MHz

  stack_call_unit dut_i (
    .clk(clk), .rst_n(rst_n), .op_code(op_code), .push_data(push_data),
    .pop_dst(pop_dst), .call_target(call_target), .pc_cur(pc_cur),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .rf_we(rf_we), .rf_waddr(rf_waddr),
    .rf_wdata(rf_wdata), .pc_next(pc_next), .sp_out(sp_out)
  );

  // behavioural stack memory: 256-word window, combinational read
  logic [15:0] mem [0:255];
  always @(posedge clk) if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
  always_comb mem_rdata = mem[mem_addr[7:0]];

  typedef struct {
    string       tag;
    logic [15:0] sp;
    logic        chk_addr;
    logic [15:0] addr;
    logic        we;
    logic [15:0] wdata;
    logic        rfwe;
    logic [2:0]  waddr;
    logic [15:0] rfdata;
    logic [15:0] npc;
  } item_t;

  item_t       q[$];
  logic [15:0] sp_m;
  logic [15:0] exp_mem [0:255];
  int          n_chk = 0;
  int          n_fail = 0;

  task automatic chk(input string tag, input string fld, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, fld, act, exp);
    end
  endtask

  // driver: applies one instruction per clock and queues its expectation
  task automatic drive(input logic [2:0] op, input logic [15:0] src, input logic [2:0] dst,
                       input logic [15:0] tgt, input logic [15:0] pc, input string tag);
    item_t it;
    @(negedge clk);
    op_code = op; push_data = src; pop_dst = dst; call_target = tgt; pc_cur = pc;
    it.tag = tag; it.sp = sp_m; it.chk_addr = 1'b0; it.addr = '0; it.we = 1'b0;
    it.wdata = '0; it.rfwe = 1'b0; it.waddr = '0; it.rfdata = '0; it.npc = pc + 16'd1;
    case (op)
      3'd1: begin
        it.chk_addr = 1'b1; it.addr = sp_m - 16'd1; it.we = 1'b1; it.wdata = src;
        exp_mem[it.addr[7:0]] = src; sp_m = sp_m - 16'd1;
      end
      3'd2: begin
        it.chk_addr = 1'b1; it.addr = sp_m; it.rfwe = 1'b1; it.waddr = dst;
        it.rfdata = exp_mem[sp_m[7:0]]; sp_m = sp_m + 16'd1;
      end
      3'd3: begin
        it.chk_addr = 1'b1; it.addr = sp_m - 16'd1; it.we = 1'b1; it.wdata = pc + 16'd1;
        it.npc = tgt; exp_mem[it.addr[7:0]] = pc + 16'd1; sp_m = sp_m - 16'd1;
      end
      3'd4: begin
        it.chk_addr = 1'b1; it.addr = sp_m; it.npc = exp_mem[sp_m[7:0]];
        sp_m = sp_m + 16'd1;
      end
      default: ;
    endcase
    q.push_back(it);
  endtask

  // monitor: compares settled outputs against the queued expectation
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (q.size() > 0) begin
        item_t e;
        e = q.pop_front();
        chk(e.tag, "sp_out", sp_out, e.sp);
        if (e.chk_addr) chk(e.tag, "mem_addr", mem_addr, e.addr);
        chk(e.tag, "mem_we", {15'd0, mem_we}, {15'd0, e.we});
        if (e.we) chk(e.tag, "mem_wdata", mem_wdata, e.wdata);
        chk(e.tag, "rf_we", {15'd0, rf_we}, {15'd0, e.rfwe});
        if (e.rfwe) begin
          chk(e.tag, "rf_waddr", {13'd0, rf_waddr}, {13'd0, e.waddr});
          chk(e.tag, "rf_wdata", rf_wdata, e.rfdata);
        end
        chk(e.tag, "pc_next", pc_next, e.npc);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    sp_m = 16'h0000;
    rst_n = 1'b0; op_code = 3'd0; push_data = '0; pop_dst = '0; call_target = '0; pc_cur = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "sp_out in reset", sp_out, 16'h0000);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    drive(3'd0, 16'h0, 3'd0, 16'h0, 16'h0040, "R1");
    drive(3'd0, 16'hAAAA, 3'd5, 16'h1234, 16'h0041, "R6");
    drive(3'd5, 16'hAAAA, 3'd1, 16'h1234, 16'h0042, "R8");
    drive(3'd6, 16'hBBBB, 3'd2, 16'h2345, 16'h0043, "R8");
    drive(3'd7, 16'hCCCC, 3'd3, 16'h3456, 16'hFFFF, "R7");  // PC wrap, no stack effect
    drive(3'd1, 16'h1111, 3'd0, 16'h0, 16'h0050, "R7");     // push from 0 lands at FFFF
    drive(3'd1, 16'h2222, 3'd0, 16'h0, 16'h0051, "R2");
    drive(3'd1, 16'h3333, 3'd0, 16'h0, 16'h0052, "R2");
    drive(3'd0, 16'h0, 3'd0, 16'h0, 16'h0053, "R2");
    drive(3'd2, 16'h0, 3'd7, 16'h0, 16'h0054, "R10");
    drive(3'd2, 16'h0, 3'd0, 16'h0, 16'h0055, "R10");
    drive(3'd2, 16'h0, 3'd3, 16'h0, 16'h0056, "R7");        // pop at FFFF returns to 0
    drive(3'd0, 16'h0, 3'd0, 16'h0, 16'h0057, "R3");
    // nested calls and returns
    drive(3'd3, 16'h0, 3'd0, 16'h0100, 16'h0010, "R4");
    drive(3'd3, 16'h0, 3'd0, 16'h0200, 16'h0105, "R4");
    drive(3'd3, 16'h0, 3'd0, 16'h0300, 16'h0205, "R9");
    drive(3'd4, 16'h0, 3'd0, 16'h0, 16'h0302, "R9");        // expect 0x0206
    drive(3'd4, 16'h0, 3'd0, 16'h0, 16'h0207, "R9");        // expect 0x0106
    drive(3'd4, 16'h0, 3'd0, 16'h0, 16'h0108, "R5");        // expect 0x0011
    // mixed: data push inside a call frame, call at PC FFFF
    drive(3'd1, 16'hBEEF, 3'd0, 16'h0, 16'h0011, "R2");
    drive(3'd3, 16'h0, 3'd0, 16'h0777, 16'hFFFF, "R7");     // link wraps to 0
    drive(3'd4, 16'h0, 3'd0, 16'h0, 16'h0778, "R5");
    drive(3'd2, 16'h0, 3'd5, 16'h0, 16'h0001, "R3");
    // deep run
    for (int i = 0; i < 40; i++)
      drive(3'd1, 16'h5A00 + 16'(i * 7), 3'd0, 16'h0, 16'(16'h0400 + i), "R2");
    for (int i = 0; i < 40; i++)
      drive(3'd2, 16'h0, 3'(i), 16'h0, 16'(16'h0500 + i), "R3");
    drive(3'd0, 16'h0, 3'd0, 16'h0, 16'h0600, "R6");
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule